// File: doc/BRIEF.md
# Thermal Threshold Interrupt Controller

This block watches an 8-bit temperature code from an on-chip sensor and compares it against up to four programmable trip points. Each trip point has a rising threshold and a separate falling threshold, which gives hysteresis. When the code crosses a rising threshold upward, a rise flag for that trip is latched. When it crosses a falling threshold downward, a fall flag is latched. Flags are masked by an enable register and merged into one level interrupt. Software clears flags by writing ones to them.

A core enable gates all comparisons. A separate control bit arms a hardware overheat output, driven whenever the code is at or above the rising threshold of the highest trip. For bring-up and test, an emulation register can substitute a programmed code for the sensor value. The substitution takes effect only after a programmed delay has counted down.

Top module: `thermal_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, except the emulation register, which reads 0x57F0_0000 (default delay in bits [31:16]). `irq` and `overheat` are low. Word addresses: 0 control, 1 rising thresholds, 2 falling thresholds, 3 interrupt enable, 4 interrupt status, 5 current temperature, 6 emulation.
- R2: The rising threshold of trip n is byte [8n+7:8n] of register 1. Status bit 4n sets two clock edges after the code moves from below that threshold to at or above it. A code that stays above the threshold sets nothing.
- R3: The falling threshold of trip n is byte [8n+7:8n] of register 2. Status bit 16+4n sets when the code moves from above that threshold to at or below it. A falling byte of zero disables that trip's fall flag.
- R4: The enable register uses the status layout and only bits 4n and 16+4n are writable. `irq` is high exactly while some status bit and its enable bit are both set.
- R5: Writing the status register clears the bits written as one and leaves the others. A flag raised in the same cycle stays set.
- R6: While control bit 0 (core enable) is clear, no status bit sets and `overheat` stays low.
- R7: `overheat` is high while control bit 0 and control bit 12 are both set and the current code is at or above the trip 3 rising threshold.
- R8: Register 5 returns the effective code sampled on the previous clock edge.
- R9: In the emulation register, bit 0 enables emulation, bits [15:8] hold the emulated code and bits [31:16] a delay. Each write reloads a counter with the delay, and the counter steps down once per cycle. While emulation is enabled and the counter is zero, the emulated code replaces the sensor code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sensor_code | input | 8 | Temperature code from the sensor |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt, OR of enabled status flags |
| overheat | output | 1 | Hardware overheat shutdown request |

## Verification
The hardest case to reach is a threshold crossing caused by the emulated code, not the sensor. It must also land on the exact cycle the delay counter reaches zero, while falling thresholds on several trips fire together. The bench holds the sensor high, programs a short delay with a low emulated code and tracks every cycle against a behavioural model. The same stimulus then checks the wait (old code still visible), the switch and the resulting fall flags. A masked-enable pass confirms that flags still latch while the interrupt stays low.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
   localparam int DATA_W      = 32;
   localparam int TH_STRIDE   = 8;
   localparam int FLAG_STRIDE = 4;
   localparam int FALL_OFS    = 16;
   localparam int CORE_BIT    = 0;
   localparam int TRIP_BIT    = 12;

   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_RISE  = 3'd1,
      RA_FALL  = 3'd2,
      RA_INTEN = 3'd3,
      RA_STAT  = 3'd4,
      RA_TEMP  = 3'd5,
      RA_EMUL  = 3'd6
   } reg_addr_e;

   function automatic logic [DATA_W-1:0] flag_mask(input int trips);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int t = 0; t < trips; t++) begin
         m[FLAG_STRIDE*t]            = 1'b1;
         m[FALL_OFS + FLAG_STRIDE*t] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/tmon_src.sv
module tmon_src #(
   parameter int CODE_W  = 8,
   parameter int DELAY_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [DELAY_W-1:0] load_delay,
   input  logic               emul_en,
   input  logic [CODE_W-1:0]  emul_code,
   input  logic [CODE_W-1:0]  sensor_code,
   output logic [CODE_W-1:0]  code_o
);
   logic [DELAY_W-1:0] cnt_q;
   logic               cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (load)     cnt_q <= load_delay;
      else if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
   end

   assign code_o = (emul_en && cnt_zero) ? emul_code : sensor_code;

   // R9: sensor code is kept while the delay is still running
   assert_wait_sensor_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> (code_o == sensor_code));

   // R9: counter steps down by one per cycle when not reloaded
   assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q != '0) && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tmon_trip_cmp.sv
module tmon_trip_cmp #(
   parameter int CODE_W = 8
) (
   input  logic              active,
   input  logic [CODE_W-1:0] prev_code,
   input  logic [CODE_W-1:0] cur_code,
   input  logic [CODE_W-1:0] rise_th,
   input  logic [CODE_W-1:0] fall_th,
   output logic              rise_evt,
   output logic              fall_evt
);
   logic fall_armed;

   assign fall_armed = (fall_th != '0);
   assign rise_evt   = active && (prev_code < rise_th) && (cur_code >= rise_th);
   assign fall_evt   = active && fall_armed && (prev_code > fall_th) && (cur_code <= fall_th);
endmodule

// File: rtl/thermal_irq_ctrl.sv
module thermal_irq_ctrl
   import tmon_pkg::*;
#(
   parameter int          CODE_W    = 8,
   parameter int          NUM_TRIPS = 4,
   parameter int          DELAY_W   = 16,
   parameter int          ADDR_W    = 3,
   parameter logic [15:0] DEF_DELAY = 16'h57F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] sensor_code,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              overheat
);
   localparam logic [DATA_W-1:0] FLAGS = flag_mask(NUM_TRIPS);
   localparam int TOP_TRIP = NUM_TRIPS - 1;

   if (CODE_W != TH_STRIDE || NUM_TRIPS < 1 || NUM_TRIPS > 4 ||
       DELAY_W != 16 || ADDR_W < 3) begin : g_param_bad
      $error("thermal_irq_ctrl: unsupported parameter set");
   end

   logic              core_en_q, trip_en_q;
   logic [31:0]       rise_q, fall_q, en_q, stat_q;
   logic [CODE_W-1:0] prev_q, cur_q, eff_code;
   logic              emul_en_q;
   logic [CODE_W-1:0] emul_code_q;
   logic [15:0]       emul_delay_q;
   logic [NUM_TRIPS-1:0] rise_ev, fall_ev;
   logic [31:0]       evt_vec;
   logic              wr_ctrl, wr_rise, wr_fall, wr_en, wr_stat, wr_emul;

   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(RA_CTRL));
   assign wr_rise = reg_wr && (reg_addr == ADDR_W'(RA_RISE));
   assign wr_fall = reg_wr && (reg_addr == ADDR_W'(RA_FALL));
   assign wr_en   = reg_wr && (reg_addr == ADDR_W'(RA_INTEN));
   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(RA_STAT));
   assign wr_emul = reg_wr && (reg_addr == ADDR_W'(RA_EMUL));

   tmon_src #(.CODE_W(CODE_W), .DELAY_W(DELAY_W)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (wr_emul),
      .load_delay (reg_wdata[31:16]),
      .emul_en    (emul_en_q),
      .emul_code  (emul_code_q),
      .sensor_code(sensor_code),
      .code_o     (eff_code)
   );

   for (genvar n = 0; n < NUM_TRIPS; n++) begin : g_trip
      tmon_trip_cmp #(.CODE_W(CODE_W)) u_cmp (
         .active   (core_en_q),
         .prev_code(prev_q),
         .cur_code (cur_q),
         .rise_th  (rise_q[TH_STRIDE*n +: CODE_W]),
         .fall_th  (fall_q[TH_STRIDE*n +: CODE_W]),
         .rise_evt (rise_ev[n]),
         .fall_evt (fall_ev[n])
      );
   end

   always_comb begin
      evt_vec = '0;
      for (int n = 0; n < NUM_TRIPS; n++) begin
         evt_vec[FLAG_STRIDE*n]            = rise_ev[n];
         evt_vec[FALL_OFS + FLAG_STRIDE*n] = fall_ev[n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_en_q    <= 1'b0;
         trip_en_q    <= 1'b0;
         rise_q       <= '0;
         fall_q       <= '0;
         en_q         <= '0;
         stat_q       <= '0;
         prev_q       <= '0;
         cur_q        <= '0;
         emul_en_q    <= 1'b0;
         emul_code_q  <= '0;
         emul_delay_q <= DEF_DELAY;
      end else begin
         prev_q <= cur_q;
         cur_q  <= eff_code;
         stat_q <= (stat_q & ~(wr_stat ? reg_wdata : 32'h0)) | evt_vec;
         if (wr_ctrl) begin
            core_en_q <= reg_wdata[CORE_BIT];
            trip_en_q <= reg_wdata[TRIP_BIT];
         end
         if (wr_rise) rise_q <= reg_wdata;
         if (wr_fall) fall_q <= reg_wdata;
         if (wr_en)   en_q   <= reg_wdata & FLAGS;
         if (wr_emul) begin
            emul_en_q    <= reg_wdata[0];
            emul_code_q  <= reg_wdata[15:8];
            emul_delay_q <= reg_wdata[31:16];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(RA_CTRL): begin
            reg_rdata[CORE_BIT] = core_en_q;
            reg_rdata[TRIP_BIT] = trip_en_q;
         end
         ADDR_W'(RA_RISE):  reg_rdata = rise_q;
         ADDR_W'(RA_FALL):  reg_rdata = fall_q;
         ADDR_W'(RA_INTEN): reg_rdata = en_q;
         ADDR_W'(RA_STAT):  reg_rdata = stat_q;
         ADDR_W'(RA_TEMP):  reg_rdata[CODE_W-1:0] = cur_q;
         ADDR_W'(RA_EMUL):  reg_rdata = {emul_delay_q, emul_code_q, 7'b0, emul_en_q};
         default:           reg_rdata = '0;
      endcase
   end

   assign irq      = |(stat_q & en_q);
   assign overheat = core_en_q && trip_en_q &&
                     (cur_q >= rise_q[TH_STRIDE*TOP_TRIP +: CODE_W]);

   // R6: no new flag can appear while the core is disabled
   assert_core_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en_q |=> ((stat_q & ~$past(stat_q)) == '0));

   // R4: the interrupt only drops through a status or enable write
   assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_stat && !wr_en) |=> irq);

   // R5: write-one-to-clear with no concurrent event
   assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && (evt_vec == '0)) |=> (stat_q == ($past(stat_q) & ~$past(reg_wdata))));
endmodule

// File: tb/thermal_irq_ctrl_test.sv
module thermal_irq_ctrl_test;
   localparam int PERIOD = 10;
   localparam int unsigned FLAGS = 32'h1111_1111;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sensor_code = 8'h00;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        irq, overheat;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   thermal_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .sensor_code(sensor_code),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .overheat(overheat)
   );

   always #(PERIOD/2) clk = ~clk;

   // behavioural reference state
   int unsigned m_ctrl, m_rise, m_fall, m_en, m_stat, m_cur, m_prev, m_emul, m_cnt;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int unsigned mread(input int unsigned a);
      case (a)
         0: return m_ctrl;
         1: return m_rise;
         2: return m_fall;
         3: return m_en;
         4: return m_stat;
         5: return m_cur;
         6: return m_emul;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_rise = 0; m_fall = 0; m_en = 0; m_stat = 0;
         m_cur = 0; m_prev = 0; m_emul = 32'h57F0_0000; m_cnt = 0;
      end else begin
         int unsigned eff, ev, nstat;
         eff = ((m_emul & 1) != 0 && m_cnt == 0) ? ((m_emul >> 8) & 255) : sensor_code;
         ev = 0;
         if ((m_ctrl & 1) != 0) begin
            for (int t = 0; t < 4; t++) begin
               int unsigned r, f;
               r = (m_rise >> (8*t)) & 255;
               f = (m_fall >> (8*t)) & 255;
               if (m_prev < r && m_cur >= r) ev |= 1 << (4*t);
               if (f != 0 && m_prev > f && m_cur <= f) ev |= 1 << (16 + 4*t);
            end
         end
         nstat = m_stat;
         if (reg_wr && reg_addr == 4) nstat &= ~reg_wdata;
         nstat |= ev;
         if (reg_wr && reg_addr == 6) m_cnt = reg_wdata >> 16;
         else if (m_cnt != 0) m_cnt--;
         if (reg_wr) begin
            case (reg_addr)
               0: m_ctrl = reg_wdata & 32'h0000_1001;
               1: m_rise = reg_wdata;
               2: m_fall = reg_wdata;
               3: m_en   = reg_wdata & FLAGS;
               6: m_emul = reg_wdata & 32'hFFFF_FF01;
               default: ;
            endcase
         end
         m_stat = nstat;
         m_prev = m_cur;
         m_cur  = eff;
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit m_ovh;
         m_ovh = ((m_ctrl & 32'h1001) == 32'h1001) && (m_cur >= ((m_rise >> 24) & 255));
         chk("R4 irq lockstep", {31'b0, irq}, {31'b0, (m_stat & m_en) != 0});
         chk("R7 overheat lockstep", {31'b0, overheat}, {31'b0, m_ovh});
         chk("R8 rdata lockstep", reg_rdata, mread(reg_addr));
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); #1;
      reg_addr = a;
      @(negedge clk);
      chk(tag, reg_rdata, exp);
   endtask

   task automatic set_code(input logic [7:0] v);
      @(negedge clk); #1;
      sensor_code = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      rd_chk(3'd0, 32'h0, "R1 ctrl reset");
      rd_chk(3'd1, 32'h0, "R1 rise reset");
      rd_chk(3'd4, 32'h0, "R1 status reset");
      rd_chk(3'd6, 32'h57F0_0000, "R1 emulation reset");
      chk("R1 irq reset", {31'b0, irq}, 32'h0);
      chk("R1 overheat reset", {31'b0, overheat}, 32'h0);

      set_code(8'h10);
      wr(3'd1, 32'h5040_3020);
      wr(3'd2, 32'h0038_2818);
      wr(3'd3, 32'hFFFF_FFFF);
      rd_chk(3'd3, 32'h1111_1111, "R4 enable mask");
      wr(3'd0, 32'h0000_0001);

      set_code(8'h25); idle(3);
      rd_chk(3'd4, 32'h0000_0001, "R2 trip0 rise");
      chk("R4 irq high", {31'b0, irq}, 32'h1);
      set_code(8'h60); idle(3);
      rd_chk(3'd4, 32'h0000_1111, "R2 all rises");
      chk("R7 overheat unarmed", {31'b0, overheat}, 32'h0);
      wr(3'd0, 32'h0000_1001); idle(1);
      chk("R7 overheat armed", {31'b0, overheat}, 32'h1);

      wr(3'd4, 32'h0000_0011);
      rd_chk(3'd4, 32'h0000_1100, "R5 partial clear");

      set_code(8'h10); idle(3);
      rd_chk(3'd4, 32'h0111_1100, "R3 falls, trip3 fall disabled");
      chk("R7 overheat below", {31'b0, overheat}, 32'h0);
      wr(3'd4, 32'hFFFF_FFFF);
      rd_chk(3'd4, 32'h0, "R5 full clear");
      chk("R4 irq low after clear", {31'b0, irq}, 32'h0);

      wr(3'd0, 32'h0000_1000);
      set_code(8'h60); idle(3);
      rd_chk(3'd4, 32'h0, "R6 core off no flags");
      chk("R6 overheat core off", {31'b0, overheat}, 32'h0);
      wr(3'd0, 32'h0000_0001); idle(3);
      rd_chk(3'd4, 32'h0, "R2 no retrigger while above");

      wr(3'd6, 32'h0005_1001);
      rd_chk(3'd5, 32'h0000_0060, "R9 delay keeps sensor");
      idle(10);
      rd_chk(3'd5, 32'h0000_0010, "R9 emulated code");
      rd_chk(3'd4, 32'h0111_0000, "R9 emulated falls");
      wr(3'd6, 32'h0000_0000); idle(3);
      rd_chk(3'd5, 32'h0000_0060, "R8 sensor after emulation off");

      wr(3'd4, 32'hFFFF_FFFF);
      wr(3'd3, 32'h0000_0001);
      set_code(8'h35); idle(3);
      rd_chk(3'd4, 32'h0100_0000, "R3 trip2 fall");
      chk("R4 irq masked", {31'b0, irq}, 32'h0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(PERIOD * 200000);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule